// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block decodes the bus writes aimed at a parallel NOR flash into commands. Each write carries a byte address and a data word whose low byte is the command code. A state machine follows the unlock-based sequences and chooses how reads are answered: array data, identification words, the query table, or erase status. It also sends single-cycle start requests to the program engine and to the erase timer.

The erase timer is a separate block. It reports three flags: the sector-erase collection window is open, an erase is running, and an erase is suspended. It also reports whether the address of the current write falls in a sector that is being erased while suspended. The memory array supplies the word that already sits at the write address, and the sequencer returns the merged program word. An identification read port answers autoselect reads from two ID parameters.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `rd_mode` is 0 (array), `bypass_on` is 0 and every request pulse is low.
- R2: The sequence 0xAA at unlock address A, 0x55 at unlock address B, then 0xA0 at A arms a program. The next write raises `prog_start` for one cycle. With it, `prog_addr` equals the write address and `prog_data` equals `array_word & wr_data`, so bits can only clear. The machine then returns to array mode.
- R3: Unlock addresses are matched only on bits [10:0] of the word address. The word address is the byte address shifted right by log2(BUS_BYTES). Any write that breaks a sequence returns the machine to array mode, and the next write arms nothing.
- R4: Command 0x90 enters identification mode (`rd_mode` 1). Word offset 0 reads MFR_ID, offset 1 reads DEV_ID, and offset 2 reads 0 (no sector protected).
- R5: From array mode, 0x98 at word address 0x55 enters query mode (`rd_mode` 2), and 0xF0 then returns to array mode. The same write from identification mode enters a query mode from which 0xF0 returns to identification mode.
- R6: The sequence 0x80, then a second unlock pair, then 0x10 at address A raises `chip_erase_start`. `rd_mode` stays 3 (status), ignoring every write including 0xF0, until the timer reports neither window nor busy. 0x10 at any other address is rejected.
- R7: The same sequence ending in 0x30 at any address raises `sect_erase_start`, and `erase_addr` carries that address. While the window is open, another 0x30 queues one more sector, and any other code resets to array mode. Once the erase is running, writes are ignored.
- R8: 0xB0 during a sector erase raises `suspend_req` and returns to array mode. In array mode, 0x30 raises `resume_req` and re-enters status mode only when the timer reports a suspension; otherwise it resets. A stray 0xB0 in array mode is ignored.
- R9: While an erase is suspended, a program aimed at a sector under erase (`sector_hit`) is dropped without `prog_start`, and a new erase sequence is rejected.
- R10: Command 0x20 sets `bypass_on`. In bypass the command cycle needs no unlock and its address is not checked. After a program the machine waits for the next bypass command. Writing 0x00 in bypass identification mode clears bypass.
- R11: Outside a program data cycle and the erase states, 0xF0 resets to array mode and clears bypass. As program data, 0xF0 is programmed like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; bits [7:0] form the command code |
| array_word | input | DATA_W | Current array contents at `wr_addr` |
| rd_addr | input | ADDR_W | Byte address for identification reads |
| erase_window | input | 1 | Timer: sector collection window open |
| erase_busy | input | 1 | Timer: erase running |
| erase_suspended | input | 1 | Timer: erase suspended |
| sector_hit | input | 1 | Timer: `wr_addr` lies in a suspended erasing sector |
| rd_mode | output | 2 | 0 array, 1 identification, 2 query, 3 status |
| bypass_on | output | 1 | Unlock bypass active |
| id_rdata | output | DATA_W | Identification word for `rd_addr` |
| prog_start | output | 1 | Program request pulse |
| prog_addr | output | ADDR_W | Program byte address |
| prog_data | output | DATA_W | Merged program word |
| sect_erase_start | output | 1 | Sector erase (or queue) request pulse |
| erase_addr | output | ADDR_W | Address inside the sector to erase |
| chip_erase_start | output | 1 | Chip erase request pulse |
| suspend_req | output | 1 | Erase suspend pulse |
| resume_req | output | 1 | Erase resume pulse |

## Verification
The bench uses a 16-bit bus (BUS_BYTES = 2) with unlock addresses 0x555 and 0x2AA and 24-bit addresses. With these values the one-bit byte-to-word shift is exercised: a byte address equal to the raw word value fails, while odd byte lanes and set bits at word bit 11 and above still match. A small timer model in the bench, with an 8-cycle window and a 20-cycle erase, reaches queuing within the window, the writes ignored while the erase runs, and suspend, resume and the rejected-sector program.

// File: rtl/nor_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state, read-mode encoding and command codes of the
// NOR command sequencer. Assumes 8-bit command codes on data bits [7:0].
package nor_seq_pkg;

    typedef enum logic [3:0] {
        S_READ, S_UL1, S_CMD, S_PROG, S_AUTO, S_CFI, S_AUTO_CFI,
        S_EUL0, S_EUL1, S_ECMD, S_CHIP, S_SECT
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_ID     = 2'd1,
        MODE_CFI    = 2'd2,
        MODE_STATUS = 2'd3
    } rd_mode_t;

    typedef struct packed {
        logic prog;
        logic sect;
        logic chip;
        logic susp;
        logic resume;
    } req_t;

    localparam logic [7:0] C_UNLOCK0 = 8'hAA;
    localparam logic [7:0] C_UNLOCK1 = 8'h55;
    localparam logic [7:0] C_ERASE   = 8'h80;
    localparam logic [7:0] C_AUTOSEL = 8'h90;
    localparam logic [7:0] C_PROGRAM = 8'hA0;
    localparam logic [7:0] C_BYPASS  = 8'h20;
    localparam logic [7:0] C_CHIP    = 8'h10;
    localparam logic [7:0] C_SECTOR  = 8'h30;
    localparam logic [7:0] C_SUSPEND = 8'hB0;
    localparam logic [7:0] C_QUERY   = 8'h98;
    localparam logic [7:0] C_RESET   = 8'hF0;
    localparam logic [7:0] C_BPEXIT  = 8'h00;
    localparam logic [10:0] QUERY_WORD = 11'h055;

endpackage

// File: rtl/nor_addr_xlat.sv
`timescale 1ns/1ps
// Module: converts a byte address into the 11-bit word address used for
// command decoding. Assumes BUS_BYTES is 1, 2 or 4 and ADDR_W >= 13.
module nor_addr_xlat #(
    parameter int ADDR_W    = 24,
    parameter int BUS_BYTES = 2
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [10:0]       word11
);
    localparam int SHIFT = (BUS_BYTES == 4) ? 2 : ((BUS_BYTES == 2) ? 1 : 0);

    logic unused_addr_bits;
    assign unused_addr_bits = ^byte_addr;

    // Select the slice that drops the byte-lane bits of the bus width.
    generate
        if (SHIFT == 0) begin : g_byte
            assign word11 = byte_addr[10:0];
        end else begin : g_wide
            assign word11 = byte_addr[SHIFT +: 11];
        end
    endgenerate
endmodule

// File: rtl/nor_id_mux.sv
`timescale 1ns/1ps
// Module: answers identification reads: offsets 0 and 1 give the two ID
// words, offset 2 reports no protection, other offsets read zero.
module nor_id_mux #(
    parameter int DATA_W = 16,
    parameter logic [DATA_W-1:0] MFR_ID = '0,
    parameter logic [DATA_W-1:0] DEV_ID = '0
) (
    input  logic [10:0]       word11,
    output logic [DATA_W-1:0] id_word
);
    // Pick the identification word for the requested offset.
    always_comb begin
        case (word11)
            11'd0:   id_word = MFR_ID;
            11'd1:   id_word = DEV_ID;
            default: id_word = '0;
        endcase
    end
endmodule

// File: rtl/nor_seq_fsm.sv
`timescale 1ns/1ps
// Module: write-cycle state machine for the unlock-based command set.
// Assumes one write per wr_en cycle and erase-timer flags that react one
// cycle after a request pulse. Emits next-cycle request strobes (fire) and
// their registered form (req).
module nor_seq_fsm
    import nor_seq_pkg::*;
#(
    parameter logic [10:0] UNLOCK_A = 11'h555,
    parameter logic [10:0] UNLOCK_B = 11'h2AA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [10:0] word11,
    input  logic [7:0] cmd,
    input  logic       erase_window,
    input  logic       erase_busy,
    input  logic       erase_suspended,
    input  logic       sector_hit,
    output seq_state_t state,
    output logic       bypass,
    output req_t       fire,
    output req_t       req
);
    seq_state_t state_n;
    logic       bypass_n;
    logic       is_a, is_b;
    logic       timer_idle;

    assign is_a = (word11 == UNLOCK_A);
    assign is_b = (word11 == UNLOCK_B);
    assign timer_idle = !erase_window && !erase_busy && !req.sect && !req.chip && !req.resume;

    // Next-state decode of one bus write plus erase completion.
    always_comb begin
        state_n  = state;
        bypass_n = bypass;
        fire     = '0;

        if ((state == S_CHIP || state == S_SECT) && timer_idle) begin
            state_n = bypass ? S_CMD : S_READ;
        end

        if (wr_en) begin
            if (cmd == C_RESET && state != S_PROG && state != S_CHIP && state != S_SECT) begin
                if (state == S_AUTO_CFI) begin
                    state_n = S_AUTO;
                end else begin
                    state_n  = S_READ;
                    bypass_n = 1'b0;
                end
            end else begin
                case (state)
                    S_READ: begin
                        if (word11 == QUERY_WORD && cmd == C_QUERY) begin
                            state_n = S_CFI;
                        end else if (cmd == C_SECTOR) begin
                            if (erase_suspended) begin
                                fire.resume = 1'b1;
                                state_n     = S_SECT;
                            end else begin
                                state_n  = S_READ;
                                bypass_n = 1'b0;
                            end
                        end else if (cmd == C_SUSPEND) begin
                            state_n = S_READ;
                        end else if (is_a && cmd == C_UNLOCK0) begin
                            state_n = S_UL1;
                        end else begin
                            state_n  = S_READ;
                            bypass_n = 1'b0;
                        end
                    end
                    S_UL1, S_EUL1: begin
                        if (is_b && cmd == C_UNLOCK1) begin
                            state_n = (state == S_UL1) ? S_CMD : S_ECMD;
                        end else begin
                            state_n  = S_READ;
                            bypass_n = 1'b0;
                        end
                    end
                    S_CMD: begin
                        if (!bypass && !is_a) begin
                            state_n  = S_READ;
                            bypass_n = 1'b0;
                        end else begin
                            case (cmd)
                                C_BYPASS:  bypass_n = 1'b1;
                                C_ERASE:   state_n  = S_EUL0;
                                C_AUTOSEL: state_n  = S_AUTO;
                                C_PROGRAM: state_n  = S_PROG;
                                default: begin
                                    state_n  = S_READ;
                                    bypass_n = 1'b0;
                                end
                            endcase
                        end
                    end
                    S_PROG: begin
                        if (!(erase_suspended && sector_hit)) begin
                            fire.prog = 1'b1;
                        end
                        if (bypass) begin
                            state_n = S_CMD;
                        end else begin
                            state_n = S_READ;
                        end
                    end
                    S_AUTO: begin
                        if (!bypass && word11 == QUERY_WORD && cmd == C_QUERY) begin
                            state_n = S_AUTO_CFI;
                        end else if (bypass && cmd != C_BPEXIT && word11 == QUERY_WORD && cmd == C_QUERY) begin
                            state_n = S_AUTO_CFI;
                        end else begin
                            state_n  = S_READ;
                            bypass_n = 1'b0;
                        end
                    end
                    S_EUL0: begin
                        if (is_a && cmd == C_UNLOCK0) begin
                            state_n = S_EUL1;
                        end else begin
                            state_n  = S_READ;
                            bypass_n = 1'b0;
                        end
                    end
                    S_ECMD: begin
                        if (!erase_suspended && cmd == C_CHIP && is_a) begin
                            fire.chip = 1'b1;
                            state_n   = S_CHIP;
                        end else if (!erase_suspended && cmd == C_SECTOR) begin
                            fire.sect = 1'b1;
                            state_n   = S_SECT;
                        end else begin
                            state_n  = S_READ;
                            bypass_n = 1'b0;
                        end
                    end
                    S_CHIP: begin
                        state_n = state_n;
                    end
                    S_SECT: begin
                        if (cmd == C_SUSPEND) begin
                            fire.susp = 1'b1;
                            state_n   = S_READ;
                        end else if (erase_window) begin
                            if (cmd == C_SECTOR) begin
                                fire.sect = 1'b1;
                                state_n   = S_SECT;
                            end else begin
                                state_n  = S_READ;
                                bypass_n = 1'b0;
                            end
                        end
                    end
                    default: begin
                        state_n  = S_READ;
                        bypass_n = 1'b0;
                    end
                endcase
            end
        end
    end

    // State, bypass flag and registered request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_READ;
            bypass <= 1'b0;
            req    <= '0;
        end else begin
            state  <= state_n;
            bypass <= bypass_n;
            req    <= fire;
        end
    end
endmodule

// File: rtl/nor_cmd_seq.sv
`timescale 1ns/1ps
// Module: top of the NOR command sequencer. Decodes bus writes, selects the
// read mode, issues program/erase/suspend/resume pulses with their address
// and merged data, and serves identification reads. Assumes array_word is
// valid for wr_addr in the write cycle.
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BUS_BYTES = 2,
    parameter logic [10:0] UNLOCK_A = 11'h555,
    parameter logic [10:0] UNLOCK_B = 11'h2AA,
    parameter logic [8*BUS_BYTES-1:0] MFR_ID = 'h0001,
    parameter logic [8*BUS_BYTES-1:0] DEV_ID = 'h227E,
    localparam int DATA_W = 8 * BUS_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] array_word,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              erase_window,
    input  logic              erase_busy,
    input  logic              erase_suspended,
    input  logic              sector_hit,
    output logic [1:0]        rd_mode,
    output logic              bypass_on,
    output logic [DATA_W-1:0] id_rdata,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              sect_erase_start,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              chip_erase_start,
    output logic              suspend_req,
    output logic              resume_req
);
    logic [10:0] wr_word, rd_word;
    seq_state_t  state;
    req_t        fire, req;
    rd_mode_t    mode;

    nor_addr_xlat #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_wr_xlat (
        .byte_addr (wr_addr),
        .word11    (wr_word)
    );

    nor_addr_xlat #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_rd_xlat (
        .byte_addr (rd_addr),
        .word11    (rd_word)
    );

    nor_id_mux #(.DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
        .word11  (rd_word),
        .id_word (id_rdata)
    );

    nor_seq_fsm #(.UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .word11          (wr_word),
        .cmd             (wr_data[7:0]),
        .erase_window    (erase_window),
        .erase_busy      (erase_busy),
        .erase_suspended (erase_suspended),
        .sector_hit      (sector_hit),
        .state           (state),
        .bypass          (bypass_on),
        .fire            (fire),
        .req             (req)
    );

    // Map the sequencer state onto the read-mode encoding.
    always_comb begin
        case (state)
            S_AUTO:            mode = MODE_ID;
            S_CFI, S_AUTO_CFI: mode = MODE_CFI;
            S_CHIP, S_SECT:    mode = MODE_STATUS;
            default:           mode = MODE_ARRAY;
        endcase
    end
    assign rd_mode = mode;

    // Capture program address and AND-merged data alongside the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr <= '0;
            prog_data <= '0;
        end else if (fire.prog) begin
            prog_addr <= wr_addr;
            prog_data <= array_word & wr_data;
        end
    end

    // Capture the sector address alongside each sector erase request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_addr <= '0;
        end else if (fire.sect) begin
            erase_addr <= wr_addr;
        end
    end

    assign prog_start       = req.prog;
    assign sect_erase_start = req.sect;
    assign chip_erase_start = req.chip;
    assign suspend_req      = req.susp;
    assign resume_req       = req.resume;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to nor_cmd_seq; observes ports only.
module nor_cmd_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] array_word,
    input logic              erase_suspended,
    input logic [1:0]        rd_mode,
    input logic              prog_start,
    input logic [DATA_W-1:0] prog_data,
    input logic              sect_erase_start,
    input logic              chip_erase_start,
    input logic              suspend_req,
    input logic              resume_req
);
    // At most one request pulse per cycle.
    p_one_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, sect_erase_start, chip_erase_start, suspend_req, resume_req}));

    // A program pulse follows a write and only clears bits.
    p_prog_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> ($past(wr_en) &&
                        ((prog_data & ~$past(array_word)) == '0) &&
                        ((prog_data & ~$past(wr_data)) == '0)));

    // Chip erase request is accompanied by status mode.
    p_chip_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_start |-> (rd_mode == 2'd3));

    // Resume only when the timer reported a suspension.
    p_resume_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> ($past(erase_suspended) && rd_mode == 2'd3));

    // Suspend lands in array mode.
    p_suspend_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> (rd_mode == 2'd0));

    // Sector erase request always comes from a write.
    p_sect_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sect_erase_start |-> ($past(wr_en) && rd_mode == 2'd3));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .wr_data          (wr_data),
    .array_word       (array_word),
    .erase_suspended  (erase_suspended),
    .rd_mode          (rd_mode),
    .prog_start       (prog_start),
    .prog_data        (prog_data),
    .sect_erase_start (sect_erase_start),
    .chip_erase_start (chip_erase_start),
    .suspend_req      (suspend_req),
    .resume_req       (resume_req)
);

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
// Directed bench for nor_cmd_seq with a small erase-timer model.
module nor_cmd_seq_test;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam logic [15:0] MFR = 16'h0001;
    localparam logic [15:0] DEV = 16'h227E;
    localparam logic [23:0] BA = 24'h000AAA;   // word 0x555 as byte address
    localparam logic [23:0] BB = 24'h000554;   // word 0x2AA as byte address

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] array_word = 16'hF0F0;
    logic [AW-1:0] rd_addr = '0;
    logic          t_window, t_busy, t_susp;
    logic          sector_hit;
    logic [1:0]    rd_mode;
    logic          bypass_on, prog_start, sect_erase_start, chip_erase_start;
    logic          suspend_req, resume_req;
    logic [DW-1:0] id_rdata, prog_data;
    logic [AW-1:0] prog_addr, erase_addr;
    logic [11:0]   t_sec;
    int            wcnt, bcnt;
    int            n_chk = 0;
    int            n_fail = 0;
    logic          finished = 1'b0;

    always #5 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .BUS_BYTES(2), .UNLOCK_A(11'h555), .UNLOCK_B(11'h2AA),
                  .MFR_ID(MFR), .DEV_ID(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .array_word(array_word), .rd_addr(rd_addr), .erase_window(t_window),
        .erase_busy(t_busy), .erase_suspended(t_susp), .sector_hit(sector_hit),
        .rd_mode(rd_mode), .bypass_on(bypass_on), .id_rdata(id_rdata),
        .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
        .sect_erase_start(sect_erase_start), .erase_addr(erase_addr),
        .chip_erase_start(chip_erase_start), .suspend_req(suspend_req),
        .resume_req(resume_req)
    );

    assign sector_hit = t_susp && (wr_addr[23:12] == t_sec);

    // Erase timer model: 8-cycle window, 20-cycle erase, suspend/resume.
    always @(posedge clk) begin
        if (!rst_n) begin
            t_window <= 1'b0; t_busy <= 1'b0; t_susp <= 1'b0;
            t_sec <= '0; wcnt <= 0; bcnt <= 0;
        end else if (sect_erase_start) begin
            t_window <= 1'b1; wcnt <= 8; t_sec <= erase_addr[23:12];
        end else if (chip_erase_start) begin
            t_busy <= 1'b1; bcnt <= 20;
        end else if (suspend_req) begin
            t_window <= 1'b0; t_busy <= 1'b0; t_susp <= 1'b1;
        end else if (resume_req) begin
            t_susp <= 1'b0; t_busy <= 1'b1; bcnt <= 20;
        end else if (t_window) begin
            if (wcnt == 0) begin t_window <= 1'b0; t_busy <= 1'b1; bcnt <= 20; end
            else wcnt <= wcnt - 1;
        end else if (t_busy) begin
            if (bcnt == 0) t_busy <= 1'b0;
            else bcnt <= bcnt - 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(BA, 16'h00AA);
        wr(BB, 16'h0055);
    endtask

    task automatic erase_prefix();
        unlock(); wr(BA, 16'h0080); unlock();
    endtask

    task automatic wait_array();
        for (int i = 0; i < 300; i++) begin
            if (rd_mode == 2'd0) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_timer();
        for (int i = 0; i < 300; i++) begin
            if (!t_window && !t_busy) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 mode", rd_mode, 0);
        chk("R1 bypass", bypass_on, 0);
        chk("R1 pulses", {prog_start, sect_erase_start, chip_erase_start, suspend_req, resume_req}, 0);
    endtask

    task automatic t_program();
        unlock(); wr(BA, 16'h00A0); wr(24'h001234, 16'h3C3C);
        chk("R2 prog_start", prog_start, 1);
        chk("R2 prog_addr", prog_addr, 24'h001234);
        chk("R2 prog_data", prog_data, 16'h3030);
        chk("R2 mode", rd_mode, 0);
        @(negedge clk);
        chk("R2 single pulse", prog_start, 0);
        unlock(); wr(BA, 16'h00A0); wr(24'h000100, 16'h00F0);
        chk("R11 F0 programmed", prog_start, 1);
        chk("R11 F0 data", prog_data, 16'h00F0);
    endtask

    task automatic t_addr();
        wr(24'h000AAB | 24'h001000, 16'h00AA);
        wr(BB | 24'h002000, 16'h0055);
        wr(BA, 16'h00A0); wr(24'h000010, 16'h0F0F);
        chk("R3 aliased unlock accepted", prog_start, 1);
        wr(BA, 16'h00AA); wr(24'h000556, 16'h0055); wr(BA, 16'h00A0); wr(24'h000010, 16'h0F0F);
        chk("R3 wrong unlock B rejected", prog_start, 0);
        wr(24'h000555, 16'h00AA); wr(BB, 16'h0055); wr(BA, 16'h00A0); wr(24'h000010, 16'h0F0F);
        chk("R3 unshifted address rejected", prog_start, 0);
        chk("R3 mode", rd_mode, 0);
    endtask

    task automatic t_autosel();
        unlock(); wr(BA, 16'h0090);
        chk("R4 mode id", rd_mode, 1);
        rd_addr = 24'h000000; #1; chk("R4 offset0", id_rdata, MFR);
        rd_addr = 24'h000002; #1; chk("R4 offset1", id_rdata, DEV);
        rd_addr = 24'h000004; #1; chk("R4 offset2", id_rdata, 0);
        wr(24'h0, 16'h00F0);
        chk("R11 F0 leaves id", rd_mode, 0);
    endtask

    task automatic t_cfi();
        wr(24'h0000AA, 16'h0098);
        chk("R5 query from array", rd_mode, 2);
        wr(24'h0, 16'h00F0);
        chk("R5 back to array", rd_mode, 0);
        unlock(); wr(BA, 16'h0090); wr(24'h0000AA, 16'h0098);
        chk("R5 query from id", rd_mode, 2);
        wr(24'h0, 16'h00F0);
        chk("R5 back to id", rd_mode, 1);
        wr(24'h0, 16'h00F0);
        chk("R5 then array", rd_mode, 0);
    endtask

    task automatic t_chip();
        erase_prefix(); wr(24'h000100, 16'h0010);
        chk("R6 wrong address rejected", chip_erase_start, 0);
        chk("R6 wrong address mode", rd_mode, 0);
        erase_prefix(); wr(BA, 16'h0010);
        chk("R6 chip pulse", chip_erase_start, 1);
        chk("R6 status", rd_mode, 3);
        wr(24'h0, 16'h00F0);
        chk("R6 F0 ignored", rd_mode, 3);
        wait_array();
        chk("R6 done", rd_mode, 0);
    endtask

    task automatic t_sector();
        erase_prefix(); wr(24'h003000, 16'h0030);
        chk("R7 sect pulse", sect_erase_start, 1);
        chk("R7 erase_addr", erase_addr, 24'h003000);
        chk("R7 status", rd_mode, 3);
        wr(24'h005000, 16'h0030);
        chk("R7 queued pulse", sect_erase_start, 1);
        chk("R7 queued addr", erase_addr, 24'h005000);
        repeat (12) @(negedge clk);
        wr(24'h0, 16'h00F0);
        chk("R7 F0 ignored while running", rd_mode, 3);
        wr(24'h006000, 16'h0030);
        chk("R7 0x30 ignored while running", sect_erase_start, 0);
        wait_array();
        chk("R7 done", rd_mode, 0);
        erase_prefix(); wr(24'h003000, 16'h0030);
        wr(24'h004000, 16'h0055);
        chk("R7 other code in window resets", rd_mode, 0);
        wait_timer();
    endtask

    task automatic t_suspend();
        erase_prefix(); wr(24'h003000, 16'h0030);
        wr(24'h0, 16'h00B0);
        chk("R8 suspend pulse", suspend_req, 1);
        chk("R8 suspend mode", rd_mode, 0);
        wr(24'h0, 16'h00B0);
        chk("R8 stray B0 ignored", {suspend_req, rd_mode}, 0);
        unlock(); wr(BA, 16'h00A0); wr(24'h003010, 16'h0012);
        chk("R9 program to erasing sector dropped", prog_start, 0);
        unlock(); wr(BA, 16'h00A0); wr(24'h008000, 16'h0012);
        chk("R9 program elsewhere", prog_start, 1);
        erase_prefix(); wr(24'h009000, 16'h0030);
        chk("R9 erase while suspended rejected", sect_erase_start, 0);
        wr(24'h0, 16'h0030);
        chk("R8 resume pulse", resume_req, 1);
        chk("R8 resume status", rd_mode, 3);
        wait_array();
        chk("R8 resumed erase finishes", rd_mode, 0);
        wr(24'h0, 16'h0030);
        chk("R8 0x30 without suspension", {resume_req, rd_mode}, 0);
    endtask

    task automatic t_bypass();
        unlock(); wr(BA, 16'h0020);
        chk("R10 bypass on", bypass_on, 1);
        wr(24'h000777, 16'h00A0); wr(24'h000400, 16'h0F0F);
        chk("R10 bypass program", prog_start, 1);
        chk("R10 stays bypass", bypass_on, 1);
        wr(24'h000123, 16'h00A0); wr(24'h000402, 16'hFF00);
        chk("R10 second program", prog_start, 1);
        wr(24'h0, 16'h0090);
        chk("R10 bypass id", rd_mode, 1);
        wr(24'h0, 16'h0000);
        chk("R10 exit bypass", {bypass_on, rd_mode}, 0);
        wr(24'h000400, 16'h00A0); wr(24'h000400, 16'h0F0F);
        chk("R10 unlock needed again", prog_start, 0);
        unlock(); wr(BA, 16'h0020);
        wr(24'h0, 16'h00F0);
        chk("R11 F0 clears bypass", bypass_on, 0);
        wr(BA, 16'h00AA); wr(24'h0, 16'h00F0); wr(BB, 16'h0055); wr(BA, 16'h00A0);
        wr(24'h000010, 16'h0001);
        chk("R11 F0 aborts unlock", prog_start, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_addr();
        t_autosel();
        t_cfi();
        t_chip();
        t_sector();
        t_suspend();
        t_bypass();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule